// File: doc/BRIEF.md
# Memory ECC error capture unit

This block sits beside the ECC checker of a DRAM controller and keeps a record of the errors the checker reports. The checker raises one of three one-cycle pulses: correctable single-bit error, uncorrectable multi-bit error, or chip-select decode error. Each pulse comes with the transaction address, the beat number within the 8-beat burst, a transaction size code and the ECC syndrome. The block stores these in capture registers. It keeps a write-one-to-clear status word and a single-bit error counter with a programmable threshold, and it drives an interrupt line.

Each error class locks the capture registers under its own rule. A multi-bit or select error freezes the capture at once. Single-bit errors keep overwriting the capture until the counter reaches the threshold. The captured address is always the start of the burst, and the beat index is stored in a separate field. A small word-addressed register port gives software access. Reads are combinational and writes take effect at the clock edge.

Top module: `ecc_err_capture`

## Requirements
- R1: When the capture is unlocked, a multi-bit error pulse loads the capture registers and sets status bit 0, which locks the capture.
- R2: When the capture is unlocked, a select error pulse with no multi-bit error in the same cycle loads the capture and sets status bit 1, which locks the capture.
- R3: When the capture is unlocked, a single-bit error whose count stays below the threshold loads the capture without locking it, so the next error overwrites it.
- R4: Each single-bit error that is captured increments the counter (saturating, read at register 2 bits [23:16]). When the count after the increment is greater than or equal to the threshold (register 2 bits [7:0], reset value 4), status bit 2 is set and the capture locks.
- R5: The status register (register 0) is cleared by writing 1s to its bits. When bits 2:0 go from nonzero to all zero, the lock is released and the counter is cleared to 0.
- R6: The captured address is the burst start address. Its low log2(DATA_W) bits read as zero (6 bits for the default 64-bit path). The low 32 bits are at register 3 and the upper bits are at register 4.
- R7: Register 5 holds the beat number in bits [2:0], the size in bits [11:8] and the error class in bits [17:16] (1 for multi-bit, 2 for select, 3 for single-bit). Register 6 holds the syndrome.
- R8: An error of any class that arrives while the capture is locked sets status bit 3 (overflow) and leaves every capture register unchanged.
- R9: When several classes arrive in one cycle, multi-bit wins over select, and select wins over single-bit. Only the winner sets its status bit, and a single-bit error that loses is not counted.
- R10: irq_o is high exactly when some status bit and its enable bit in register 1 are both 1.
- R11: After reset all status, enable, counter and capture values are zero, and the threshold is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sbe_i | input | 1 | Single-bit error pulse |
| mbe_i | input | 1 | Multi-bit error pulse |
| sel_err_i | input | 1 | Chip-select error pulse |
| err_addr_i | input | ADDR_W | Transaction address |
| err_beat_i | input | 3 | Beat index within the burst |
| err_size_i | input | SIZE_W | Transaction size code |
| err_syn_i | input | SYN_W | ECC syndrome |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt |

## Verification
The bench goes after the step where the counter reaches the threshold. A design that is off by one there would lock one error early or one error late, and the captured address would differ from the model. It fires errors at locked captures. A design that dropped the lock check would show an overwritten address, and one that missed the overflow flag would show status bit 3 clear. It sends classes together to catch an inverted priority or a losing single-bit error that still counts. It also clears only some status bits, which catches a counter that resets while a lock is still held.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_MBE  = 2'd1,
    CLS_SEL  = 2'd2,
    CLS_SBE  = 2'd3
  } err_cls_e;

  localparam int unsigned STAT_W = 4;
  localparam int unsigned ST_MBE = 0;
  localparam int unsigned ST_SEL = 1;
  localparam int unsigned ST_SBE = 2;
  localparam int unsigned ST_OVF = 3;

  localparam logic [2:0] REG_STATUS  = 3'd0;
  localparam logic [2:0] REG_IRQ_EN  = 3'd1;
  localparam logic [2:0] REG_SBE     = 3'd2;
  localparam logic [2:0] REG_ADDR_LO = 3'd3;
  localparam logic [2:0] REG_ADDR_HI = 3'd4;
  localparam logic [2:0] REG_ATTR    = 3'd5;
  localparam logic [2:0] REG_SYN     = 3'd6;
endpackage

// File: rtl/ecc_cap_arb.sv
module ecc_cap_arb
  import ecc_cap_pkg::*;
(
  input  logic     sbe_i,
  input  logic     mbe_i,
  input  logic     sel_i,
  output err_cls_e cls_o,
  output logic     any_o
);
  always_comb begin
    if (mbe_i)      cls_o = CLS_MBE;
    else if (sel_i) cls_o = CLS_SEL;
    else if (sbe_i) cls_o = CLS_SBE;
    else            cls_o = CLS_NONE;
  end
  assign any_o = sbe_i | mbe_i | sel_i;
endmodule

// File: rtl/ecc_cap_sbe_cnt.sv
module ecc_cap_sbe_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_inc;

  // saturating increment
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign hit_o   = inc_i && (cnt_inc >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned ALIGN_LSB = 6,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned SYN_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  err_cls_e          cls_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        beat_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SYN_W-1:0]  syn_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        beat_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [SYN_W-1:0]  syn_o,
  output err_cls_e          cls_o
);
  logic [ADDR_W-1:0] addr_aligned;

  generate
    if (ALIGN_LSB == 0) begin : g_noalign
      assign addr_aligned = addr_i;
    end else begin : g_align
      assign addr_aligned = {addr_i[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      beat_o <= '0;
      size_o <= '0;
      syn_o  <= '0;
      cls_o  <= CLS_NONE;
    end else if (load_i) begin
      addr_o <= addr_aligned;
      beat_o <= beat_i;
      size_o <= size_i;
      syn_o  <= syn_i;
      cls_o  <= cls_i;
    end
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned SYN_W   = 8,
  parameter int unsigned CNT_W   = 8,
  parameter logic [CNT_W-1:0] THR_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic              sel_err_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [2:0]        err_beat_i,
  input  logic [SIZE_W-1:0] err_size_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned BURST_BYTES = 8 * (DATA_W / 8);
  localparam int unsigned ALIGN_LSB   = $clog2(BURST_BYTES);
  localparam int unsigned HI_W        = ADDR_W - 32;

  logic [STAT_W-1:0] status_q, status_d, stat_set, stat_clr;
  logic [STAT_W-1:0] irq_en_q;
  logic [CNT_W-1:0]  thr_q, sbe_cnt;
  logic              lock, err_any, load, sbe_hit, release_lk;
  err_cls_e          arb_cls, cap_cls;
  logic [ADDR_W-1:0] cap_addr;
  logic [2:0]        cap_beat;
  logic [SIZE_W-1:0] cap_size;
  logic [SYN_W-1:0]  cap_syn;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  ecc_cap_arb u_arb (
    .sbe_i (sbe_i),
    .mbe_i (mbe_i),
    .sel_i (sel_err_i),
    .cls_o (arb_cls),
    .any_o (err_any)
  );

  assign lock = status_q[ST_MBE] | status_q[ST_SEL] | status_q[ST_SBE];
  assign load = err_any & ~lock;

  ecc_cap_sbe_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (load && arb_cls == CLS_SBE),
    .clr_i  (release_lk),
    .thr_i  (thr_q),
    .cnt_o  (sbe_cnt),
    .hit_o  (sbe_hit)
  );

  ecc_cap_store #(
    .ADDR_W    (ADDR_W),
    .ALIGN_LSB (ALIGN_LSB),
    .SIZE_W    (SIZE_W),
    .SYN_W     (SYN_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cls_i  (arb_cls),
    .addr_i (err_addr_i),
    .beat_i (err_beat_i),
    .size_i (err_size_i),
    .syn_i  (err_syn_i),
    .addr_o (cap_addr),
    .beat_o (cap_beat),
    .size_o (cap_size),
    .syn_o  (cap_syn),
    .cls_o  (cap_cls)
  );

  // set wins over a clear in the same cycle
  always_comb begin
    stat_set         = '0;
    stat_set[ST_MBE] = load && arb_cls == CLS_MBE;
    stat_set[ST_SEL] = load && arb_cls == CLS_SEL;
    stat_set[ST_SBE] = sbe_hit;
    stat_set[ST_OVF] = err_any && lock;
    stat_clr = (reg_we_i && reg_addr_i == REG_STATUS) ? reg_wdata_i[STAT_W-1:0] : '0;
    status_d = (status_q & ~stat_clr) | stat_set;
  end

  assign release_lk = lock && (status_d[ST_SBE:ST_MBE] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_en_q <= '0;
      thr_q    <= THR_RST;
    end else begin
      status_q <= status_d;
      if (reg_we_i && reg_addr_i == REG_IRQ_EN) irq_en_q <= reg_wdata_i[STAT_W-1:0];
      if (reg_we_i && reg_addr_i == REG_SBE)    thr_q    <= reg_wdata_i[CNT_W-1:0];
    end
  end

  assign irq_o = |(status_q & irq_en_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_STATUS:  reg_rdata_o[STAT_W-1:0] = status_q;
      REG_IRQ_EN:  reg_rdata_o[STAT_W-1:0] = irq_en_q;
      REG_SBE: begin
        reg_rdata_o[CNT_W-1:0]  = thr_q;
        reg_rdata_o[16 +: CNT_W] = sbe_cnt;
      end
      REG_ADDR_LO: reg_rdata_o = cap_addr[31:0];
      REG_ADDR_HI: reg_rdata_o[HI_W-1:0] = cap_addr[ADDR_W-1:32];
      REG_ATTR: begin
        reg_rdata_o[2:0]         = cap_beat;
        reg_rdata_o[8 +: SIZE_W] = cap_size;
        reg_rdata_o[17:16]       = cap_cls;
      end
      REG_SYN:     reg_rdata_o[SYN_W-1:0] = cap_syn;
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int unsigned ADDR_W    = 40,
  parameter int unsigned ALIGN_LSB = 6,
  parameter int unsigned CNT_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sbe_i,
  input logic              mbe_i,
  input logic              sel_err_i,
  input logic [ADDR_W-1:0] err_addr_i,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [3:0]        status_q,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [CNT_W-1:0]  sbe_cnt
);
  logic lk, any, clr_wr;
  assign lk     = |status_q[2:0];
  assign any    = sbe_i | mbe_i | sel_err_i;
  assign clr_wr = reg_we_i && reg_addr_i == 3'd0;

  // R1
  mbe_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk && mbe_i) |=> status_q[0]);
  // R2
  sel_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk && sel_err_i && !mbe_i) |=> status_q[1]);
  // R9
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk && mbe_i && (sel_err_i || sbe_i)) |=> (!status_q[1] && !status_q[2]));
  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk && any) |=> status_q[3]);
  // R8
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk && !clr_wr) |=> $stable(cap_addr));
  // R6
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk && any) |=> (cap_addr[ADDR_W-1:ALIGN_LSB] == $past(err_addr_i[ADDR_W-1:ALIGN_LSB])
                      && cap_addr[ALIGN_LSB-1:0] == '0));
  // R5
  cnt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lk) |-> (sbe_cnt == '0));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(
  .ADDR_W    (ADDR_W),
  .ALIGN_LSB (ALIGN_LSB),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sbe_i      (sbe_i),
  .mbe_i      (mbe_i),
  .sel_err_i  (sel_err_i),
  .err_addr_i (err_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .status_q   (status_q),
  .cap_addr   (cap_addr),
  .sbe_cnt    (sbe_cnt)
);

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sbe_i = 0, mbe_i = 0, sel_err_i = 0;
  logic [39:0] err_addr_i = '0;
  logic [2:0]  err_beat_i = '0;
  logic [3:0]  err_size_i = '0;
  logic [7:0]  err_syn_i = '0;
  logic        reg_we_i = 0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  always #5 clk_i = ~clk_i;

  ecc_err_capture u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model
  logic [3:0]  m_stat = '0, m_en = '0;
  int          m_cnt = 0;
  logic [7:0]  m_thr = 8'd4;
  logic [39:0] m_addr = '0;
  logic [2:0]  m_beat = '0;
  logic [3:0]  m_size = '0;
  logic [7:0]  m_syn = '0;
  logic [1:0]  m_cls = '0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1;
    v = reg_rdata_o;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    rd(3'd0, v); chk({tag, " R5 status"}, v, {28'd0, m_stat});
    rd(3'd1, v); chk({tag, " R10 irq_en"}, v, {28'd0, m_en});
    rd(3'd2, v); chk({tag, " R4 thr/count"}, v, {8'd0, 8'(m_cnt), 8'd0, m_thr});
    rd(3'd3, v); chk({tag, " R6 addr_lo"}, v, m_addr[31:0]);
    rd(3'd4, v); chk({tag, " R6 addr_hi"}, v, {24'd0, m_addr[39:32]});
    rd(3'd5, v); chk({tag, " R7 attr"}, v, {14'd0, m_cls, 4'd0, m_size, 5'd0, m_beat});
    rd(3'd6, v); chk({tag, " R7 syndrome"}, v, {24'd0, m_syn});
    chk({tag, " R10 irq_o"}, {31'd0, irq_o}, {31'd0, |(m_stat & m_en)});
  endtask

  task automatic do_err(bit s, bit m, bit c, logic [39:0] a, logic [2:0] b,
                        logic [3:0] z, logic [7:0] y);
    bit lk;
    @(negedge clk_i);
    sbe_i = s; mbe_i = m; sel_err_i = c;
    err_addr_i = a; err_beat_i = b; err_size_i = z; err_syn_i = y;
    lk = |m_stat[2:0];
    if (s | m | c) begin
      if (lk) m_stat[3] = 1'b1;
      else begin
        m_addr = {a[39:6], 6'd0}; m_beat = b; m_size = z; m_syn = y;
        m_cls = m ? 2'd1 : (c ? 2'd2 : 2'd3);
        if (m) m_stat[0] = 1'b1;
        else if (c) m_stat[1] = 1'b1;
        else begin
          if (m_cnt < 255) m_cnt++;
          if (m_cnt >= int'(m_thr)) m_stat[2] = 1'b1;
        end
      end
    end
    @(negedge clk_i);
    sbe_i = 0; mbe_i = 0; sel_err_i = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bit was;
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    if (a == 3'd0) begin
      was = |m_stat[2:0];
      m_stat &= ~d[3:0];
      if (was && !(|m_stat[2:0])) m_cnt = 0;
    end else if (a == 3'd1) m_en = d[3:0];
    else if (a == 3'd2) m_thr = d[7:0];
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check_all("R11 reset");

    // R3: below threshold, overwrite
    do_err(1, 0, 0, 40'h00_8000_0001, 3'd3, 4'd2, 8'h5a);
    check_all("R3 first sbe");
    do_err(1, 0, 0, 40'h12_3456_7fff, 3'd7, 4'd1, 8'hc3);
    check_all("R3 overwrite R6 align");
    // R4: reach threshold
    do_err(1, 0, 0, 40'h00_0000_0100, 3'd1, 4'd3, 8'h11);
    check_all("R4 count3");
    do_err(1, 0, 0, 40'h00_0000_0240, 3'd2, 4'd4, 8'h22);
    check_all("R4 lock at threshold");
    // R8: locked
    do_err(1, 0, 0, 40'h00_0000_0380, 3'd5, 4'd5, 8'h33);
    check_all("R8 sbe while locked");
    do_err(0, 1, 0, 40'h00_0000_0480, 3'd5, 4'd5, 8'h44);
    check_all("R8 mbe while locked");
    // R5: partial and full clear
    wr(3'd0, 32'h8);
    check_all("R5 clear ovf only");
    wr(3'd0, 32'h4);
    check_all("R5 release");
    // R1
    do_err(0, 1, 0, 40'h01_0000_0abc, 3'd6, 4'd8, 8'h99);
    check_all("R1 mbe lock");
    do_err(0, 0, 1, 40'h02_0000_0000, 3'd0, 4'd0, 8'h00);
    check_all("R1 R8 sel after mbe");
    wr(3'd0, 32'hf);
    // R2
    do_err(0, 0, 1, 40'hff_ffff_ffff, 3'd4, 4'hf, 8'hff);
    check_all("R2 sel lock");
    wr(3'd0, 32'hf);
    // R9
    do_err(1, 1, 1, 40'h00_1111_1111, 3'd2, 4'd6, 8'h12);
    check_all("R9 all three");
    wr(3'd0, 32'hf);
    do_err(1, 0, 1, 40'h00_2222_2222, 3'd3, 4'd7, 8'h34);
    check_all("R9 sel over sbe");
    wr(3'd0, 32'hf);
    // R10
    do_err(0, 1, 0, 40'h00_0000_0040, 3'd1, 4'd1, 8'h01);
    check_all("R10 enable off");
    wr(3'd1, 32'h1);
    check_all("R10 enable on");
    wr(3'd0, 32'h1);
    check_all("R10 cleared");
    // R4 threshold zero and one
    wr(3'd2, 32'h0);
    do_err(1, 0, 0, 40'h00_0000_1000, 3'd0, 4'd0, 8'h0f);
    check_all("R4 thr0");
    wr(3'd0, 32'h4);
    wr(3'd2, 32'h2);

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 65) begin
        logic [2:0] f;
        f = 3'($urandom_range(1, 7));
        if ($urandom_range(0, 1) == 1) f = 3'b001;
        do_err(f[0], f[1], f[2], {8'($urandom), 32'($urandom)}, 3'($urandom),
               4'($urandom), 8'($urandom));
      end else if (op < 88) wr(3'd0, 32'($urandom_range(0, 15)));
      else if (op < 94) wr(3'd2, 32'($urandom_range(0, 6)));
      else wr(3'd1, 32'($urandom_range(0, 15)));
      check_all("rand R3 R4 R5 R8 R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule